// File: doc/BRIEF.md
# Secure-Banked Private Peripheral Decoder

This block sits between a processor's load/store path and the registers of its private peripheral space (0xE000_0000 to 0xE00F_FFFF). Every request carries a secure attribute and a user (unprivileged) attribute. In the same cycle, a combinational decode steers the request to one of four downstream targets: the system-register block, the secure timer bank, the non-secure timer bank, or an optional error-reporting register block. The block forwards the 12-bit offset within the target's page, the write data and the security attribute, which it rewrites where needed.

The regions overlap and are resolved by a fixed priority. The timer window beats the system-register block. Either of those beats the error-reporting block, and every target beats the built-in default responder. When the security feature is enabled, a second window at 0xE002_E000 mirrors the system registers and the timer. A secure request there is re-issued to the real target as a non-secure access. A non-secure request there is terminated locally. Accesses that no target claims are also terminated locally. The block answers each terminated access one cycle later with read data of zero, or with a bus error when the request was unprivileged.

Top module: `ppb_router`

## Requirements
- R1: A request whose address lies outside 0xE000_0000..0xE00F_FFFF asserts no target select and produces no response.
- R2: Addresses 0xE000_E010..0xE000_E0EF select a timer bank and never the system-register block; 0xE000_E0F0 selects the system-register block.
- R3: Addresses 0xE000_E000..0xE000_EFFF outside the timer window assert `sysreg_sel`, with `fwd_offset` equal to address bits [11:0].
- R4: With the security feature enabled, a timer access whose forwarded secure attribute is 1 asserts `tmr_s_sel`; otherwise it asserts `tmr_ns_sel`.
- R5: With the error block enabled, 0xE000_5000..0xE000_5FFF asserts `errblk_sel`; with it disabled, that range goes to the default responder.
- R6: A privileged request to unclaimed space gives `rsp_valid`=1, `rsp_err`=0 and `rsp_rdata`=0 exactly one cycle later. A write there changes nothing, and a later read still returns 0.
- R7: An unprivileged request to unclaimed space gives `rsp_valid`=1 and `rsp_err`=1 one cycle later.
- R8: A secure request to the alias window (0xE002_E000..0xE002_EFFF) is forwarded with `fwd_secure`=0 and the same 12-bit offset. It goes to `tmr_ns_sel` for 0xE002_E010..0xE002_E0EF and to `sysreg_sel` otherwise.
- R9: A non-secure request to the alias window asserts no select. One cycle later it gets a zero-data OK response when privileged and an error when unprivileged.
- R10: With the security feature disabled, the alias window is treated as unclaimed space, and timer accesses always assert `tmr_ns_sel`.
- R11: At most one target select is high in any cycle, and none is high while `req_valid` is 0. Write, user and write-data signals pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| req_user | input | 1 | Unprivileged attribute of the request |
| sysreg_sel | output | 1 | System-register block select |
| tmr_s_sel | output | 1 | Secure timer bank select |
| tmr_ns_sel | output | 1 | Non-secure timer bank select |
| errblk_sel | output | 1 | Error-reporting block select |
| fwd_offset | output | 12 | Offset within the target page |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_secure | output | 1 | Forwarded (possibly rewritten) secure attribute |
| fwd_user | output | 1 | Forwarded user attribute |
| rsp_valid | output | 1 | Local response valid (one cycle after a terminated request) |
| rsp_rdata | output | 32 | Local response read data (always zero) |
| rsp_err | output | 1 | Local response is a bus error |

## Verification
The assertions check the following on every cycle:
- at most one select is high, and no select is high for an idle or out-of-space request;
- a timer-window hit never reaches the system registers;
- the secure timer bank is only chosen for a forwarded secure access;
- a secure alias access always leaves with its secure attribute cleared;
- a terminated privileged request is followed by an OK response, and any error response follows an unprivileged request.

Only the bench scenarios can show the rest:
- the exact window edges (0xE000_E0EF against 0xE000_E0F0, and the two ends of the error block);
- the forwarded offsets;
- that a write to unclaimed space leaves later reads at zero;
- how the decode changes between the secure-enabled instance and the instance built without security and without the error block.

// File: rtl/ppb_pkg.sv
// Package: shared target encoding and the fixed address map of the
// private peripheral decoder. Assumes a 32-bit byte address.
package ppb_pkg;

    typedef enum logic [2:0] {
        PPB_TGT_NONE   = 3'd0,
        PPB_TGT_SYSREG = 3'd1,
        PPB_TGT_TMR    = 3'd2,
        PPB_TGT_ERRBLK = 3'd3,
        PPB_TGT_TERM   = 3'd4
    } ppb_tgt_e;

    localparam logic [31:0] PPB_SPACE_BASE  = 32'hE000_0000;
    localparam logic [31:0] PPB_SPACE_SIZE  = 32'h0010_0000;
    localparam logic [31:0] PPB_SYS_BASE    = 32'hE000_E000;
    localparam logic [31:0] PPB_PAGE_SIZE   = 32'h0000_1000;
    localparam logic [31:0] PPB_TMR_BASE    = 32'hE000_E010;
    localparam logic [31:0] PPB_TMR_SIZE    = 32'h0000_00E0;
    localparam logic [31:0] PPB_ALIAS_DELTA = 32'h0002_0000;
    localparam logic [31:0] PPB_ERR_BASE    = 32'hE000_5000;

endpackage

// File: rtl/ppb_window.sv
// Module: single address window comparator.
// Asserts hit when addr lies in [BASE, BASE+SIZE). Assumes the window
// does not wrap the top of the address space.
module ppb_window #(
    parameter int unsigned     AW   = 32,
    parameter logic [AW-1:0]   BASE = '0,
    parameter logic [AW-1:0]   SIZE = '1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [AW-1:0] rel;

    // Offset from the window base; unsigned compare covers both ends.
    always_comb begin
        rel = addr - BASE;
        hit = (rel < SIZE);
    end
endmodule

// File: rtl/ppb_decode.sv
// Module: priority decoder for the private peripheral space.
// Priority: timer > system registers > alias window > error block > default.
// Purely combinational. Assumes windows as listed in ppb_pkg.
module ppb_decode
    import ppb_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter bit          SECURE_EN = 1'b1,
    parameter bit          ERRBLK_EN = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic          secure,
    output ppb_tgt_e      tgt,
    output logic          via_alias,
    output logic          eff_secure
);
    logic hit_space, hit_sys, hit_tmr, hit_asys, hit_atmr, hit_err;

    ppb_window #(.AW(AW), .BASE(PPB_SPACE_BASE), .SIZE(PPB_SPACE_SIZE))
        u_space (.addr(addr), .hit(hit_space));
    ppb_window #(.AW(AW), .BASE(PPB_SYS_BASE), .SIZE(PPB_PAGE_SIZE))
        u_sys (.addr(addr), .hit(hit_sys));
    ppb_window #(.AW(AW), .BASE(PPB_TMR_BASE), .SIZE(PPB_TMR_SIZE))
        u_tmr (.addr(addr), .hit(hit_tmr));

    generate
        if (SECURE_EN) begin : g_alias
            ppb_window #(.AW(AW), .BASE(PPB_SYS_BASE + PPB_ALIAS_DELTA), .SIZE(PPB_PAGE_SIZE))
                u_asys (.addr(addr), .hit(hit_asys));
            ppb_window #(.AW(AW), .BASE(PPB_TMR_BASE + PPB_ALIAS_DELTA), .SIZE(PPB_TMR_SIZE))
                u_atmr (.addr(addr), .hit(hit_atmr));
        end else begin : g_no_alias
            assign hit_asys = 1'b0;
            assign hit_atmr = 1'b0;
        end

        if (ERRBLK_EN) begin : g_err
            ppb_window #(.AW(AW), .BASE(PPB_ERR_BASE), .SIZE(PPB_PAGE_SIZE))
                u_err (.addr(addr), .hit(hit_err));
        end else begin : g_no_err
            assign hit_err = 1'b0;
        end
    endgenerate

    // Fixed-priority resolution of overlapping windows.
    always_comb begin
        tgt       = PPB_TGT_NONE;
        via_alias = 1'b0;
        if (!hit_space) begin
            tgt = PPB_TGT_NONE;
        end else if (hit_tmr) begin
            tgt = PPB_TGT_TMR;
        end else if (hit_sys) begin
            tgt = PPB_TGT_SYSREG;
        end else if (hit_asys) begin
            if (secure) begin
                tgt       = hit_atmr ? PPB_TGT_TMR : PPB_TGT_SYSREG;
                via_alias = 1'b1;
            end else begin
                tgt = PPB_TGT_TERM;
            end
        end else if (hit_err) begin
            tgt = PPB_TGT_ERRBLK;
        end else begin
            tgt = PPB_TGT_TERM;
        end
    end

    // Alias re-issue drops the secure attribute.
    assign eff_secure = secure & ~via_alias;
endmodule

// File: rtl/ppb_term_resp.sv
// Module: local responder for terminated accesses.
// Registers one response per terminated request: zero data, error
// for unprivileged requests. Synchronous active-low reset.
module ppb_term_resp #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          term_hit,
    input  logic          user,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err
);
    // Capture the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= term_hit;
            rsp_err   <= term_hit & user;
            rsp_rdata <= '0;
        end
    end
endmodule

// File: rtl/ppb_router.sv
// Module: top of the secure-banked private peripheral decoder.
// Routes each request to the system registers, a timer bank or the error
// block, and rewrites the secure attribute for alias re-issues. Unclaimed
// and non-secure alias accesses are answered locally one cycle later.
// Assumes at most one request per cycle and no back-pressure.
module ppb_router
    import ppb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned OFS_W     = 12,
    parameter bit          SECURE_EN = 1'b1,
    parameter bit          ERRBLK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_user,
    output logic              sysreg_sel,
    output logic              tmr_s_sel,
    output logic              tmr_ns_sel,
    output logic              errblk_sel,
    output logic [OFS_W-1:0]  fwd_offset,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_secure,
    output logic              fwd_user,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    ppb_tgt_e tgt;
    logic     via_alias;
    logic     eff_secure;
    logic     is_tmr;
    logic     tmr_secure;

    ppb_decode #(.AW(ADDR_W), .SECURE_EN(SECURE_EN), .ERRBLK_EN(ERRBLK_EN)) u_dec (
        .addr       (req_addr),
        .secure     (req_secure),
        .tgt        (tgt),
        .via_alias  (via_alias),
        .eff_secure (eff_secure)
    );

    // Target selects, gated by request valid.
    always_comb begin
        is_tmr     = req_valid && (tgt == PPB_TGT_TMR);
        tmr_secure = SECURE_EN && eff_secure;
        sysreg_sel = req_valid && (tgt == PPB_TGT_SYSREG);
        errblk_sel = req_valid && (tgt == PPB_TGT_ERRBLK);
        tmr_s_sel  = is_tmr && tmr_secure;
        tmr_ns_sel = is_tmr && !tmr_secure;
    end

    // Forwarded request fields.
    always_comb begin
        fwd_offset = req_addr[OFS_W-1:0];
        fwd_write  = req_write;
        fwd_wdata  = req_wdata;
        fwd_secure = eff_secure;
        fwd_user   = req_user;
    end

    ppb_term_resp #(.DW(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .term_hit  (req_valid && (tgt == PPB_TGT_TERM)),
        .user      (req_user),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );
endmodule

// File: rtl/ppb_router_chk.sv
// Module: assertion checker bound to ppb_router. Observes ports only.
module ppb_router_chk #(
    parameter bit SECURE_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_secure,
    input logic        req_user,
    input logic        sysreg_sel,
    input logic        tmr_s_sel,
    input logic        tmr_ns_sel,
    input logic        errblk_sel,
    input logic        fwd_secure,
    input logic        rsp_valid,
    input logic        rsp_err
);
    logic in_space, in_tmr, in_alias, any_sel;

    // Independent window checks for the properties.
    always_comb begin
        in_space = (req_addr[31:20] == 12'hE00);
        in_tmr   = (req_addr >= 32'hE000_E010) && (req_addr < 32'hE000_E0F0);
        in_alias = SECURE_EN && (req_addr[31:12] == 20'hE002E);
        any_sel  = sysreg_sel | tmr_s_sel | tmr_ns_sel | errblk_sel;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sysreg_sel, tmr_s_sel, tmr_ns_sel, errblk_sel})); // R11
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !any_sel); // R11
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_space) |-> !any_sel); // R1
    AST_OUTSIDE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_space) |=> !rsp_valid); // R1
    AST_TMR_OVER_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_tmr) |-> (!sysreg_sel && (tmr_s_sel || tmr_ns_sel))); // R2
    AST_SECURE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_s_sel |-> fwd_secure); // R4
    AST_ALIAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secure && in_alias) |-> (!fwd_secure && (sysreg_sel || tmr_ns_sel))); // R8
    AST_PRIV_TERM_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_space && !any_sel && !req_user) |=> (rsp_valid && !rsp_err)); // R6
    AST_ERR_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_space && !any_sel && req_user) |=> (rsp_valid && rsp_err)); // R7
endmodule

bind ppb_router ppb_router_chk #(.SECURE_EN(SECURE_EN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_secure (req_secure),
    .req_user   (req_user),
    .sysreg_sel (sysreg_sel),
    .tmr_s_sel  (tmr_s_sel),
    .tmr_ns_sel (tmr_ns_sel),
    .errblk_sel (errblk_sel),
    .fwd_secure (fwd_secure),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err)
);

// File: tb/ppb_router_tb_top.sv
// Scoreboard bench: the driver checks combinational forwarding and queues
// the expected local response; the monitor pops it one edge later.
module ppb_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_secure = 1'b0;
    logic        req_user = 1'b0;

    logic        a_sys, a_ts, a_tn, a_err, a_fw, a_fs, a_fu, a_rv, a_re;
    logic [11:0] a_ofs;
    logic [31:0] a_wd, a_rd;
    logic        b_sys, b_ts, b_tn, b_err, b_fw, b_fs, b_fu, b_rv, b_re;
    logic [11:0] b_ofs;
    logic [31:0] b_wd, b_rd;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic       valid;
        logic       err;
        string      tag;
    } rsp_exp_t;
    rsp_exp_t q_a[$];
    rsp_exp_t q_b[$];

    always #2.5 clk = ~clk;

    ppb_router #(.SECURE_EN(1'b1), .ERRBLK_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_secure(req_secure),
        .req_user(req_user), .sysreg_sel(a_sys), .tmr_s_sel(a_ts), .tmr_ns_sel(a_tn),
        .errblk_sel(a_err), .fwd_offset(a_ofs), .fwd_write(a_fw), .fwd_wdata(a_wd),
        .fwd_secure(a_fs), .fwd_user(a_fu), .rsp_valid(a_rv), .rsp_rdata(a_rd),
        .rsp_err(a_re));

    ppb_router #(.SECURE_EN(1'b0), .ERRBLK_EN(1'b0)) dut_ns_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_secure(req_secure),
        .req_user(req_user), .sysreg_sel(b_sys), .tmr_s_sel(b_ts), .tmr_ns_sel(b_tn),
        .errblk_sel(b_err), .fwd_offset(b_ofs), .fwd_write(b_fw), .fwd_wdata(b_wd),
        .fwd_secure(b_fs), .fwd_user(b_fu), .rsp_valid(b_rv), .rsp_rdata(b_rd),
        .rsp_err(b_re));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected decode from the requirements: sel = {sys, tmr_s, tmr_ns, err}.
    task automatic model(input logic [31:0] a, input bit v, input bit s, input bit u,
                         input bit sen, input bit een,
                         output logic [3:0] sel, output logic fsec, output rsp_exp_t r);
        bit space, tmr, sys, asys, atmr, errb, term;
        space = (a[31:20] == 12'hE00);
        tmr   = (a >= 32'hE000_E010) && (a <= 32'hE000_E0EF);
        sys   = (a[31:12] == 20'hE000E);
        asys  = sen && (a[31:12] == 20'hE002E);
        atmr  = sen && (a >= 32'hE002_E010) && (a <= 32'hE002_E0EF);
        errb  = een && (a[31:12] == 20'hE0005);
        sel = 4'b0; fsec = s; term = 1'b0;
        if (!space) begin
        end else if (tmr) begin
            sel = (sen && s) ? 4'b0100 : 4'b0010;
        end else if (sys) begin
            sel = 4'b1000;
        end else if (asys) begin
            if (s) begin
                fsec = 1'b0;
                sel  = atmr ? 4'b0010 : 4'b1000;
            end else term = 1'b1;
        end else if (errb) sel = 4'b0001;
        else term = 1'b1;
        if (!v) begin sel = 4'b0; term = 1'b0; end
        r.valid = term;
        r.err   = term && u;
    endtask

    // Drive one request for one cycle and check forwarding on both instances.
    task automatic drive(input bit v, input logic [31:0] a, input bit s, input bit u,
                         input bit w, input string tag);
        logic [3:0] se_a, se_b;
        logic fs_a, fs_b;
        rsp_exp_t r_a, r_b;
        @(negedge clk);
        req_valid = v; req_addr = a; req_secure = s; req_user = u;
        req_write = w; req_wdata = a ^ 32'h5A5A_0F0F;
        model(a, v, s, u, 1'b1, 1'b1, se_a, fs_a, r_a);
        model(a, v, s, u, 1'b0, 1'b0, se_b, fs_b, r_b);
        r_a.tag = tag; r_b.tag = tag;
        #1;
        chk({a_sys, a_ts, a_tn, a_err} == se_a, {tag, " sel"}, 64'({a_sys, a_ts, a_tn, a_err}), 64'(se_a));
        chk({b_sys, b_ts, b_tn, b_err} == se_b, {tag, " sel nosec R10"}, 64'({b_sys, b_ts, b_tn, b_err}), 64'(se_b));
        if (se_a != 4'b0) begin
            chk(a_fs == fs_a, {tag, " fwd_secure"}, 64'(a_fs), 64'(fs_a));
            chk(a_ofs == a[11:0], {tag, " offset R3"}, 64'(a_ofs), 64'(a[11:0]));
            chk(a_fw == w && a_fu == u && a_wd == req_wdata, {tag, " passthru R11"},
                64'({a_fw, a_fu}), 64'({w, u}));
        end
        q_a.push_back(r_a);
        q_b.push_back(r_b);
    endtask

    // Monitor: compare the registered local response after each edge.
    always @(posedge clk) begin
        #1;
        if (q_a.size() > 0) begin
            rsp_exp_t e;
            e = q_a.pop_front();
            chk(a_rv == e.valid && (!e.valid || (a_re == e.err && a_rd == 32'h0)),
                {e.tag, " rsp"}, 64'({a_rv, a_re}), 64'({e.valid, e.err}));
        end
        if (q_b.size() > 0) begin
            rsp_exp_t e;
            e = q_b.pop_front();
            chk(b_rv == e.valid && (!e.valid || (b_re == e.err && b_rd == 32'h0)),
                {e.tag, " rsp nosec R10"}, 64'({b_rv, b_re}), 64'({e.valid, e.err}));
        end
    end

    initial begin
        #(5 * 20000);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!a_rv && !b_rv && !a_rd[0], "reset rsp R6", 64'({a_rv, b_rv}), 64'd0);
        rst_n = 1'b1;
        drive(1'b0, 32'hE000_E000, 1'b1, 1'b0, 1'b0, "idle R11");
        drive(1'b1, 32'hE010_0000, 1'b0, 1'b0, 1'b0, "outside top R1");
        drive(1'b1, 32'h2000_0000, 1'b1, 1'b1, 1'b1, "outside low R1");
        drive(1'b1, 32'hE000_E000, 1'b0, 1'b0, 1'b0, "sys base R3");
        drive(1'b1, 32'hE000_EFFC, 1'b1, 1'b0, 1'b1, "sys top R3");
        drive(1'b1, 32'hE000_E00C, 1'b0, 1'b1, 1'b0, "sys below tmr R3");
        drive(1'b1, 32'hE000_E010, 1'b1, 1'b0, 1'b0, "tmr secure R4");
        drive(1'b1, 32'hE000_E010, 1'b0, 1'b0, 1'b1, "tmr nonsec R4");
        drive(1'b1, 32'hE000_E0EC, 1'b1, 1'b1, 1'b0, "tmr top R2");
        drive(1'b1, 32'hE000_E0F0, 1'b1, 1'b0, 1'b0, "past tmr R2");
        drive(1'b1, 32'hE000_5000, 1'b0, 1'b0, 1'b0, "err base R5");
        drive(1'b1, 32'hE000_5FFC, 1'b1, 1'b0, 1'b0, "err top R5");
        drive(1'b1, 32'hE000_4FFC, 1'b0, 1'b0, 1'b0, "below err R6");
        drive(1'b1, 32'hE000_1000, 1'b0, 1'b0, 1'b1, "dflt write R6");
        drive(1'b1, 32'hE000_1000, 1'b0, 1'b0, 1'b0, "dflt readback R6");
        drive(1'b1, 32'hE000_1000, 1'b1, 1'b1, 1'b0, "dflt user R7");
        drive(1'b1, 32'hE00F_FFFC, 1'b0, 1'b1, 1'b1, "dflt top user R7");
        drive(1'b1, 32'hE002_E004, 1'b1, 1'b0, 1'b1, "alias sys R8");
        drive(1'b1, 32'hE002_E020, 1'b1, 1'b0, 1'b0, "alias tmr R8");
        drive(1'b1, 32'hE002_E0F0, 1'b1, 1'b1, 1'b0, "alias past tmr R8");
        drive(1'b1, 32'hE002_E020, 1'b0, 1'b0, 1'b1, "alias ns priv R9");
        drive(1'b1, 32'hE002_E020, 1'b0, 1'b0, 1'b0, "alias ns readback R9");
        drive(1'b1, 32'hE002_E800, 1'b0, 1'b1, 1'b0, "alias ns user R9");
        drive(1'b1, 32'hE002_F000, 1'b1, 1'b0, 1'b0, "past alias R6");
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, 32'hE000_E000 + 32'(i * 16), i[0], i[1], i[2], "sweep R2");
            drive(1'b1, 32'hE002_E000 + 32'(i * 16), i[1], i[0], i[2], "alias sweep R8");
        end
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "drain R11");
        drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "drain R11");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule